// File: doc/BRIEF.md
# Mission Time Counter with Desynchronisation Flag

This block keeps the on-board time as two fields: a 32-bit coarse count of seconds and a 16-bit fine count of binary fractions of a second. Both fields run from a dedicated time-base clock of 24.576 MHz. A prescaler divides that clock by 375, so the fine field steps 65536 times per second. When the fine field rolls over, the lower 31 bits of the coarse field step by one. The top coarse bit is a flag. It is set when no synchronising tick has arrived for a set number of seconds.

Software and the network link live in a separate system clock domain. A one-cycle tick from the link re-aligns the time. The tick clears the fine field and the prescaler. If a seconds value was loaded beforehand, the tick also applies that value. Tick and load requests reach the time domain through toggle synchronisers. The time comes back through a request/acknowledge snapshot, so each coarse/fine pair shown to the system side was taken in a single time-base cycle.

Top module: `tm_mission_time`

## Requirements
- R1: The fine field steps by one once every PRESCALE_MAX+1 time-base cycles. With the default of 374 this gives 65536 steps per second at 24.576 MHz.
- R2: When the fine field steps from all ones, it becomes zero and coarse bits [30:0] step by one. Coarse bits [30:0] roll from 0x7FFFFFFF to 0, and bit 31 is not touched by this carry.
- R3: A tick sets the fine field and the prescaler to zero. If no seconds value is pending, coarse bits [30:0] keep their value.
- R4: A load stores a 31-bit seconds value as pending. The value takes effect at the next tick, and only then, as coarse bits [30:0]. A pending value survives any length of time without a tick.
- R5: A load with no following tick leaves the reported time unchanged.
- R6: Coarse bit 31 is set once DESYNC_SECONDS fine rollovers have passed without a tick. It stays set until a tick arrives. A tick clears the bit and restarts the count of seconds.
- R7: The reported coarse and fine values are always a pair taken in the same time-base cycle. They refresh continuously, and they change only when a snapshot is accepted.
- R8: A synchronous active-low reset clears the counters, the pending load, the desync state and the reported time to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for tick, load and the reported time |
| timeClk | input | 1 | Time-base clock |
| rstN | input | 1 | Synchronous active-low reset, applied in both domains |
| tickIn | input | 1 | One-cycle tick from the link (sysClk domain) |
| loadEn | input | 1 | One-cycle strobe that captures loadSeconds |
| loadSeconds | input | COARSE_W-1 | Seconds value to apply at the next tick |
| coarseOut | output | COARSE_W | Reported seconds; the top bit is the desync flag |
| fineOut | output | FINE_W | Reported fraction of a second |

## Verification
The main sequence is a set of load-then-tick cases. The bench then waits a chosen number of time-base cycles and reads the time.

- A wait of half a second shows that a load is applied at the tick.
- A wait of one and a half seconds shows the coarse carry.
- A load near 0x7FFFFFFF shows the wrap of the 31-bit seconds field.
- A case with a tick but no load shows that a tick alone keeps the seconds.

Further tests check four more behaviours:

- A load with no tick must not change the time.
- Waits of 2.5 and 3.5 seconds bracket the desync threshold, and a tick then clears the flag.
- A stream of reads must never go backwards, which a torn coarse/fine pair would break.
- A reset issued while a load is pending must discard that load.

// File: rtl/tm_pkg.sv
package tm_pkg;
  // One-cycle strobes from control into the time-base datapath
  typedef struct packed {
    logic tick;   // re-align time, apply pending load
    logic load;   // capture loadHold as pending seconds
    logic snap;   // capture the time pair into the hold register
  } tmStrobe_t;
endpackage

// File: rtl/tm_tgl_sync.sv
module tm_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tglIn,
  output logic level
);
  logic [STAGES-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[STAGES-2:0], tglIn};
  end

  assign level = shiftReg[STAGES-1];
endmodule

// File: rtl/tm_ctrl.sv
module tm_ctrl
  import tm_pkg::*;
#(
  parameter int COARSE_W    = 32,
  parameter int FINE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                timeClk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                loadEn,
  input  logic [COARSE_W-2:0] loadSeconds,
  input  logic [COARSE_W-1:0] holdCoarse,
  input  logic [FINE_W-1:0]   holdFine,
  output tmStrobe_t           stb,
  output logic [COARSE_W-2:0] loadHold,
  output logic [COARSE_W-1:0] coarseOut,
  output logic [FINE_W-1:0]   fineOut
);
  localparam int N_REQ    = 2;
  localparam int REQ_TICK = 0;
  localparam int REQ_LOAD = 1;

  logic [N_REQ-1:0] reqTgl, reqLvl, reqPrev, reqPulse;
  logic snapReq, snapReqLvl, snapAck, snapAckLvl;

  // System side: tick and load requests as toggles
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      reqTgl   <= '0;
      loadHold <= '0;
    end else begin
      if (tickIn) reqTgl[REQ_TICK] <= ~reqTgl[REQ_TICK];
      if (loadEn) begin
        loadHold         <= loadSeconds;
        reqTgl[REQ_LOAD] <= ~reqTgl[REQ_LOAD];
      end
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    tm_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(timeClk), .rstN(rstN), .tglIn(reqTgl[g]), .level(reqLvl[g])
    );
  end

  tm_tgl_sync #(.STAGES(SYNC_STAGES)) u_snapReqSync (
    .clk(timeClk), .rstN(rstN), .tglIn(snapReq), .level(snapReqLvl)
  );
  tm_tgl_sync #(.STAGES(SYNC_STAGES)) u_snapAckSync (
    .clk(sysClk), .rstN(rstN), .tglIn(snapAck), .level(snapAckLvl)
  );

  // Time side: edge detection and snapshot acknowledge
  always_ff @(posedge timeClk) begin
    if (!rstN) begin
      reqPrev <= '0;
      snapAck <= 1'b0;
    end else begin
      reqPrev <= reqLvl;
      snapAck <= snapReqLvl;
    end
  end

  assign reqPulse = reqLvl ^ reqPrev;
  assign stb.tick = reqPulse[REQ_TICK];
  assign stb.load = reqPulse[REQ_LOAD];
  assign stb.snap = snapReqLvl ^ snapAck;

  // System side: accept the answered snapshot, then ask for the next one
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      snapReq   <= 1'b0;
      coarseOut <= '0;
      fineOut   <= '0;
    end else if (snapAckLvl == snapReq) begin
      coarseOut <= holdCoarse;
      fineOut   <= holdFine;
      snapReq   <= ~snapReq;
    end
  end

  // R7: reported pair only moves when a snapshot is accepted
  a_r7_out_held: assert property (@(posedge sysClk) disable iff (!rstN)
    (snapAckLvl != snapReq) |=> ($stable(coarseOut) && $stable(fineOut)));
endmodule

// File: rtl/tm_datapath.sv
module tm_datapath
  import tm_pkg::*;
#(
  parameter int COARSE_W       = 32,
  parameter int FINE_W         = 16,
  parameter int PRESCALE_MAX   = 374,
  parameter int DESYNC_SECONDS = 60
) (
  input  logic                timeClk,
  input  logic                rstN,
  input  tmStrobe_t           stb,
  input  logic [COARSE_W-2:0] loadHold,
  output logic [COARSE_W-1:0] holdCoarse,
  output logic [FINE_W-1:0]   holdFine
);
  localparam int PRE_W = $clog2(PRESCALE_MAX + 1);
  localparam int DS_W  = $clog2(DESYNC_SECONDS + 1);
  localparam int LOW_W = COARSE_W - 1;
  localparam logic [PRE_W-1:0] PRE_TOP   = PRE_W'(PRESCALE_MAX);
  localparam logic [DS_W-1:0]  DS_LIMIT  = DS_W'(DESYNC_SECONDS);
  localparam logic [DS_W-1:0]  DS_LAST   = DS_W'(DESYNC_SECONDS - 1);
  localparam logic [FINE_W-1:0] FINE_TOP = '1;

  logic [PRE_W-1:0]  presc;
  logic [FINE_W-1:0] fine;
  logic [LOW_W-1:0]  coarseLow, pendingVal;
  logic [DS_W-1:0]   dsCnt;
  logic              desyncFlag, pending;
  logic              fineStep, fineWrap;

  assign fineStep = (presc == PRE_TOP);
  assign fineWrap = fineStep && (fine == FINE_TOP);

  always_ff @(posedge timeClk) begin
    if (!rstN) begin
      presc      <= '0;
      fine       <= '0;
      coarseLow  <= '0;
      dsCnt      <= '0;
      desyncFlag <= 1'b0;
      pending    <= 1'b0;
      pendingVal <= '0;
    end else if (stb.tick) begin
      presc      <= '0;
      fine       <= '0;
      dsCnt      <= '0;
      desyncFlag <= 1'b0;
      if (pending) coarseLow <= pendingVal;
      pending    <= stb.load;
      if (stb.load) pendingVal <= loadHold;
    end else begin
      presc <= fineStep ? '0 : presc + 1'b1;
      if (fineStep) fine <= fine + 1'b1;
      if (fineWrap) begin
        coarseLow <= coarseLow + 1'b1;
        if (dsCnt != DS_LIMIT) dsCnt <= dsCnt + 1'b1;
        if (dsCnt == DS_LAST)  desyncFlag <= 1'b1;
      end
      if (stb.load) begin
        pending    <= 1'b1;
        pendingVal <= loadHold;
      end
    end
  end

  // Hold register read by the system side during a snapshot
  always_ff @(posedge timeClk) begin
    if (!rstN) begin
      holdCoarse <= '0;
      holdFine   <= '0;
    end else if (stb.snap) begin
      holdCoarse <= {desyncFlag, coarseLow};
      holdFine   <= fine;
    end
  end

  a_r1_presc_range: assert property (@(posedge timeClk) disable iff (!rstN)
    presc <= PRE_TOP);
  a_r1_fine_idle: assert property (@(posedge timeClk) disable iff (!rstN)
    (!stb.tick && !fineStep) |=> $stable(fine));
  a_r2_coarse_carry: assert property (@(posedge timeClk) disable iff (!rstN)
    (fineWrap && !stb.tick) |=> (coarseLow == LOW_W'($past(coarseLow) + 1'b1)));
  a_r3_tick_clears: assert property (@(posedge timeClk) disable iff (!rstN)
    stb.tick |=> (fine == '0 && presc == '0));
  a_r4_pending_kept: assert property (@(posedge timeClk) disable iff (!rstN)
    (pending && !stb.tick) |=> pending);
  a_r6_flag_sticky: assert property (@(posedge timeClk) disable iff (!rstN)
    (desyncFlag && !stb.tick) |=> desyncFlag);
  a_r6_tick_resync: assert property (@(posedge timeClk) disable iff (!rstN)
    stb.tick |=> !desyncFlag);
endmodule

// File: rtl/tm_mission_time.sv
module tm_mission_time
  import tm_pkg::*;
#(
  parameter int COARSE_W       = 32,
  parameter int FINE_W         = 16,
  parameter int PRESCALE_MAX   = 374,
  parameter int DESYNC_SECONDS = 60,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                sysClk,
  input  logic                timeClk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                loadEn,
  input  logic [COARSE_W-2:0] loadSeconds,
  output logic [COARSE_W-1:0] coarseOut,
  output logic [FINE_W-1:0]   fineOut
);
  tmStrobe_t           stb;
  logic [COARSE_W-2:0] loadHold;
  logic [COARSE_W-1:0] holdCoarse;
  logic [FINE_W-1:0]   holdFine;

  tm_ctrl #(
    .COARSE_W(COARSE_W), .FINE_W(FINE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .sysClk(sysClk), .timeClk(timeClk), .rstN(rstN),
    .tickIn(tickIn), .loadEn(loadEn), .loadSeconds(loadSeconds),
    .holdCoarse(holdCoarse), .holdFine(holdFine),
    .stb(stb), .loadHold(loadHold),
    .coarseOut(coarseOut), .fineOut(fineOut)
  );

  tm_datapath #(
    .COARSE_W(COARSE_W), .FINE_W(FINE_W),
    .PRESCALE_MAX(PRESCALE_MAX), .DESYNC_SECONDS(DESYNC_SECONDS)
  ) u_datapath (
    .timeClk(timeClk), .rstN(rstN), .stb(stb), .loadHold(loadHold),
    .holdCoarse(holdCoarse), .holdFine(holdFine)
  );
endmodule

// File: tb/test_tm_mission_time.sv
module test_tm_mission_time;
  localparam int SYS_PERIOD  = 40;
  localparam int TIME_PERIOD = 41;
  localparam int FINE_W = 5;
  localparam int PRE    = 2;     // 3 time cycles per fine step
  localparam int DSEC   = 3;
  localparam int SEC    = (PRE + 1) * (1 << FINE_W);   // 96 cycles
  localparam int HALF   = SEC / 2;
  localparam int FLO    = 6;
  localparam int FHI    = 24;

  localparam int NV = 6;
  localparam bit          VLOAD [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [30:0] VVAL  [NV] = '{31'h100, 31'h12345678, 31'h0,
                                          31'h5, 31'h7FFFFFFF, 31'h0};
  localparam int          VWAIT [NV] = '{HALF, SEC + HALF, HALF,
                                          2 * SEC + HALF, SEC + HALF, HALF};
  localparam logic [31:0] VEXP  [NV] = '{32'h100, 32'h12345679, 32'h12345679,
                                          32'h7, 32'h0, 32'h0};

  logic sysClk = 0, timeClk = 0, rstN = 0, tickIn = 0, loadEn = 0;
  logic [30:0] loadSeconds = '0;
  logic [31:0] coarseOut;
  logic [FINE_W-1:0] fineOut;
  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #(SYS_PERIOD / 2) sysClk = ~sysClk;
  always #(TIME_PERIOD / 2.0) timeClk = ~timeClk;

  tm_mission_time #(
    .COARSE_W(32), .FINE_W(FINE_W), .PRESCALE_MAX(PRE), .DESYNC_SECONDS(DSEC)
  ) i_tm_mission_time (
    .sysClk(sysClk), .timeClk(timeClk), .rstN(rstN), .tickIn(tickIn),
    .loadEn(loadEn), .loadSeconds(loadSeconds),
    .coarseOut(coarseOut), .fineOut(fineOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic sysWait(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic doTick();
    @(negedge sysClk) tickIn = 1;
    @(negedge sysClk) tickIn = 0;
  endtask

  task automatic doLoad(input logic [30:0] v);
    @(negedge sysClk) begin loadEn = 1; loadSeconds = v; end
    @(negedge sysClk) loadEn = 0;
    sysWait(6);
  endtask

  task automatic waitTime(input int n);
    repeat (n) @(posedge timeClk);
    @(negedge sysClk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge sysClk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish();
    end
  end

  initial begin
    logic [36:0] prevVal, curVal;
    bit mono;
    // R8: reset state
    sysWait(10);
    chk("R8 reset coarse", coarseOut, 0);
    chk("R8 reset fine", fineOut, 0);
    rstN = 1;
    // R1: free run from reset for half a second
    waitTime(HALF);
    chk("R1 coarse after half second", coarseOut, 0);
    chkRange("R1 fine rate", fineOut, FLO, FHI);

    // R2 R3 R4: table of load/tick/wait cases
    for (int i = 0; i < NV; i++) begin
      if (VLOAD[i]) doLoad(VVAL[i]);
      doTick();
      waitTime(VWAIT[i]);
      chk($sformatf("R4 R2 R3 vector %0d coarse", i), coarseOut, VEXP[i]);
      chkRange($sformatf("R1 R3 vector %0d fine", i), fineOut, FLO, FHI);
    end

    // R5: load without tick leaves the time alone
    doTick();
    doLoad(31'h55);
    waitTime(HALF);
    chk("R5 load without tick", coarseOut, 0);
    // R4: pending value survives and applies at next tick
    doTick();
    waitTime(HALF);
    chk("R4 pending applied at tick", coarseOut, 32'h55);

    // R6: desync flag around the threshold
    doTick();
    waitTime(2 * SEC + HALF);
    chk("R6 flag clear at 2.5 s", coarseOut, 32'h57);
    waitTime(SEC);
    chk("R6 flag set at 3.5 s", coarseOut, 32'h80000058);
    waitTime(SEC);
    chk("R6 flag sticky, seconds run", coarseOut, 32'h80000059);
    doTick();
    waitTime(HALF);
    chk("R6 tick clears flag", coarseOut, 32'h59);

    // R7: consistent pairs never go backwards
    doTick();
    sysWait(12);
    prevVal = {coarseOut, fineOut};
    mono = 1;
    for (int k = 0; k < 60; k++) begin
      sysWait(5);
      curVal = {coarseOut, fineOut};
      if (curVal < prevVal) mono = 0;
      prevVal = curVal;
    end
    chk("R7 reads monotonic", mono, 1);

    // R8: reset drops a pending load
    doLoad(31'h77);
    @(negedge sysClk) rstN = 0;
    sysWait(10);
    chk("R8 mid-run reset coarse", coarseOut, 0);
    chk("R8 mid-run reset fine", fineOut, 0);
    @(negedge sysClk) rstN = 1;
    sysWait(4);
    doTick();
    waitTime(HALF);
    chk("R8 pending cleared by reset", coarseOut, 0);

    finish();
  end
endmodule